// File: doc/BRIEF.md
# Dependence Latency Scoreboard

This block sits in front of an in-order issue stage and decides, cycle by cycle, whether the instruction being presented may start. Each candidate instruction carries an operation class, an optional destination register and up to two optional source registers. For every architectural register the block remembers which class last wrote it and how many cycles have passed since that write issued. From these it derives a stall count for the candidate and a ready flag.

Dependence cost depends on the kind of hazard. A read of a register that is still being produced waits for the producer's latency, unless a bypass entry for that producer/consumer class pair applies, in which case the entry's latency is used instead. A rewrite of a register still in flight waits for the clamped difference between the two classes' latencies. A write to a register that earlier instructions only read costs nothing. Bypass entries may be guarded by external condition bits; among matching entries, the first guarded entry whose condition holds wins, otherwise the unguarded one applies.

Functional-unit conflicts, renaming and operand data are outside this block.

Top module: `dep_scoreboard`

## Requirements
- R1: After reset every register is ready, so any candidate sees stall_o = 0 and ready_o = 1.
- R2: Class encoding on cls_i is 0 simple integer, 1 multiply, 2 divide, 3 float, with default result latencies 2, 4, 9 and 3. A source reading a register written k cycles earlier (k = 1 on the cycle after issue) stalls for max(latency - k, 0).
- R3: With no guard bit set, a float result read by a simple, multiply or divide instruction uses latency 4 instead of 3.
- R4: Guard bit 0 of guard_i selects latency 2 for a float result read by multiply or divide; guard bit 1 selects latency 3 for a float result read by multiply; when both apply the bit 0 entry wins, and a guard that does not cover the consumer class falls back to the unguarded entry.
- R5: A producer/consumer pair that no bypass entry covers (e.g. float to float) uses the producer's default latency.
- R6: A destination matching an in-flight register stalls for max(max(Lprod - Lcons, 0) - k, 0), using default latencies.
- R7: Writing a register that earlier instructions only read adds no stall.
- R8: Register 0 and operands whose enable is low never cause a stall; an accepted instruction with destination 0 or dst_en_i low updates no entry.
- R9: An instruction is accepted only when issue_valid_i and ready_o are both high; a rejected instruction changes no entry, and with inputs held the stall counts down by one per cycle.
- R10: stall_o is the maximum of the three operand costs, and ready_o is high exactly when stall_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Candidate instruction present |
| cls_i | input | 2 | Candidate class |
| dst_i | input | AW | Destination register |
| dst_en_i | input | 1 | Destination present |
| src0_i | input | AW | First source register |
| src0_en_i | input | 1 | First source present |
| src1_i | input | AW | Second source register |
| src1_en_i | input | 1 | Second source present |
| guard_i | input | 2 | Bypass guard conditions |
| ready_o | output | 1 | Candidate may issue this cycle |
| stall_o | output | 4 | Cycles the candidate still has to wait |

## Verification
The bench aims at the bypass selection order: both guards set on a float-to-multiply pair, a guard that covers a different consumer class, and float-to-float, where a wrong priority or a stray match gives a stall off by one or two. It drives output dependences in both latency orders, since a missing clamp would wrap the difference into a huge stall. Rejected issues and disabled destination fields are followed by reads of the same register, so a design that writes on rejection or ignores the enable shows a spurious stall. Reads and writes of register 0 check that it never creates a dependence.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  localparam int CNT_W      = 4;
  localparam int NUM_GUARDS = 2;
  localparam int NUM_BYP    = 3;
  localparam logic [CNT_W-1:0] MAX_LAT = 4'd9;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_MUL = 2'd1,
    CLS_DIV = 2'd2,
    CLS_FP  = 2'd3
  } op_cls_e;

  typedef struct packed {
    op_cls_e          prod;
    logic [3:0]       cons_mask;  // bit index = consumer class
    logic             guarded;
    logic [0:0]       gsel;
    logic [CNT_W-1:0] lat;
  } byp_ent_t;

  function automatic logic [CNT_W-1:0] dflt_lat(input op_cls_e c);
    case (c)
      CLS_INT: dflt_lat = 4'd2;
      CLS_MUL: dflt_lat = 4'd4;
      CLS_DIV: dflt_lat = MAX_LAT;
      default: dflt_lat = 4'd3;
    endcase
  endfunction

  // Table order is priority order among guarded entries.
  function automatic byp_ent_t byp_ent(input int idx);
    byp_ent_t e;
    case (idx)
      0:       e = '{prod: CLS_FP, cons_mask: 4'b0110, guarded: 1'b1, gsel: 1'b0, lat: 4'd2};
      1:       e = '{prod: CLS_FP, cons_mask: 4'b0010, guarded: 1'b1, gsel: 1'b1, lat: 4'd3};
      default: e = '{prod: CLS_FP, cons_mask: 4'b0111, guarded: 1'b0, gsel: 1'b0, lat: 4'd4};
    endcase
    return e;
  endfunction
endpackage

// File: rtl/dsb_reg_file.sv
module dsb_reg_file
  import dsb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int NUM_RD   = 3,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  op_cls_e          wr_cls_i,
  input  logic [AW-1:0]    rd_addr_i [NUM_RD],
  output logic [CNT_W-1:0] rd_age_o  [NUM_RD],
  output op_cls_e          rd_cls_o  [NUM_RD]
);
  localparam logic [CNT_W-1:0] AGE_SAT = '1;

  logic [CNT_W-1:0] age_q [NUM_REGS];
  op_cls_e          cls_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[r] <= AGE_SAT;
        cls_q[r] <= CLS_INT;
      end else if (wr_en_i && wr_addr_i == AW'(r)) begin
        age_q[r] <= CNT_W'(1);
        cls_q[r] <= wr_cls_i;
      end else if (age_q[r] != AGE_SAT) begin
        age_q[r] <= age_q[r] + CNT_W'(1);
      end
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rd_age_o[p] = age_q[rd_addr_i[p]];
    assign rd_cls_o[p] = cls_q[rd_addr_i[p]];
  end
endmodule

// File: rtl/dsb_bypass_sel.sv
module dsb_bypass_sel
  import dsb_pkg::*;
(
  input  op_cls_e                 prod_cls_i,
  input  op_cls_e                 cons_cls_i,
  input  logic [NUM_GUARDS-1:0]   guard_i,
  output logic [CNT_W-1:0]        lat_o
);
  byp_ent_t         ent;
  logic             g_hit, u_hit, match;
  logic [CNT_W-1:0] g_lat, u_lat;

  always_comb begin
    g_hit = 1'b0;
    u_hit = 1'b0;
    g_lat = '0;
    u_lat = '0;
    ent   = '0;
    match = 1'b0;
    for (int i = 0; i < NUM_BYP; i++) begin
      ent   = byp_ent(i);
      match = (ent.prod == prod_cls_i) && ent.cons_mask[cons_cls_i];
      if (match && ent.guarded && guard_i[ent.gsel] && !g_hit) begin
        g_hit = 1'b1;
        g_lat = ent.lat;
      end
      if (match && !ent.guarded && !u_hit) begin
        u_hit = 1'b1;
        u_lat = ent.lat;
      end
    end
    if (g_hit)      lat_o = g_lat;
    else if (u_hit) lat_o = u_lat;
    else            lat_o = dflt_lat(prod_cls_i);
  end
endmodule

// File: rtl/dsb_hazard.sv
module dsb_hazard
  import dsb_pkg::*;
(
  input  logic             en_i,
  input  logic [CNT_W-1:0] need_i,
  input  logic [CNT_W-1:0] age_i,
  output logic [CNT_W-1:0] rem_o
);
  assign rem_o = (en_i && need_i > age_i) ? need_i - age_i : '0;
endmodule

// File: rtl/dep_scoreboard.sv
module dep_scoreboard
  import dsb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  issue_valid_i,
  input  logic [1:0]            cls_i,
  input  logic [AW-1:0]         dst_i,
  input  logic                  dst_en_i,
  input  logic [AW-1:0]         src0_i,
  input  logic                  src0_en_i,
  input  logic [AW-1:0]         src1_i,
  input  logic                  src1_en_i,
  input  logic [NUM_GUARDS-1:0] guard_i,
  output logic                  ready_o,
  output logic [CNT_W-1:0]      stall_o
);
  localparam int NUM_OPS = 3;  // 0,1 sources, 2 destination
  localparam int NUM_SRC = 2;

  op_cls_e          cons_cls;
  logic [AW-1:0]    op_addr [NUM_OPS];
  logic             op_en   [NUM_OPS];
  logic [CNT_W-1:0] op_age  [NUM_OPS];
  op_cls_e          op_cls  [NUM_OPS];
  logic [CNT_W-1:0] op_need [NUM_OPS];
  logic [CNT_W-1:0] op_rem  [NUM_OPS];
  logic [CNT_W-1:0] waw_p, waw_c;
  logic             accept, wr_en;

  assign cons_cls   = op_cls_e'(cls_i);
  assign op_addr[0] = src0_i;
  assign op_addr[1] = src1_i;
  assign op_addr[2] = dst_i;
  assign op_en[0]   = src0_en_i && (src0_i != '0);
  assign op_en[1]   = src1_en_i && (src1_i != '0);
  assign op_en[2]   = dst_en_i  && (dst_i  != '0);

  assign accept = issue_valid_i && ready_o;
  assign wr_en  = accept && op_en[2];

  dsb_reg_file #(
    .NUM_REGS (NUM_REGS),
    .NUM_RD   (NUM_OPS)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (dst_i),
    .wr_cls_i  (cons_cls),
    .rd_addr_i (op_addr),
    .rd_age_o  (op_age),
    .rd_cls_o  (op_cls)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_byp
    dsb_bypass_sel u_byp (
      .prod_cls_i (op_cls[s]),
      .cons_cls_i (cons_cls),
      .guard_i    (guard_i),
      .lat_o      (op_need[s])
    );
  end

  // Output dependence: clamped default-latency difference.
  assign waw_p      = dflt_lat(op_cls[2]);
  assign waw_c      = dflt_lat(cons_cls);
  assign op_need[2] = (waw_p > waw_c) ? waw_p - waw_c : '0;

  for (genvar o = 0; o < NUM_OPS; o++) begin : g_haz
    dsb_hazard u_haz (
      .en_i   (op_en[o]),
      .need_i (op_need[o]),
      .age_i  (op_age[o]),
      .rem_o  (op_rem[o])
    );
  end

  always_comb begin
    stall_o = '0;
    for (int o = 0; o < NUM_OPS; o++)
      if (op_rem[o] > stall_o) stall_o = op_rem[o];
  end

  assign ready_o = (stall_o == '0);
endmodule

// File: rtl/dep_scoreboard_checker.sv
module dep_scoreboard_checker
  import dsb_pkg::*;
#(
  parameter int AW = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  issue_valid_i,
  input logic [1:0]            cls_i,
  input logic [AW-1:0]         dst_i,
  input logic                  dst_en_i,
  input logic [AW-1:0]         src0_i,
  input logic                  src0_en_i,
  input logic [AW-1:0]         src1_i,
  input logic                  src1_en_i,
  input logic [NUM_GUARDS-1:0] guard_i,
  input logic                  ready_o,
  input logic [CNT_W-1:0]      stall_o
);
  logic acc;
  logic [3*AW+6+NUM_GUARDS-1:0] ins;
  assign acc = issue_valid_i && ready_o;
  assign ins = {issue_valid_i, cls_i, dst_i, dst_en_i, src0_i, src0_en_i,
                src1_i, src1_en_i, guard_i};

  // R2: every latency is at least 2, so a read one cycle after the write stalls
  a_r2_raw_blocks_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && dst_en_i && dst_i != '0) |=>
      (!(src0_en_i && src0_i == $past(dst_i)) || stall_o != '0));

  // R8: no live operand means no stall
  a_r8_no_operands_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(src0_en_i && src0_i != '0) && !(src1_en_i && src1_i != '0) &&
     !(dst_en_i && dst_i != '0)) |-> ready_o);

  // R10: one cycle after issue at most MAX_LAT-1 remains
  a_r10_stall_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o <= MAX_LAT - CNT_W'(1));

  // R9: without acceptance and with held inputs the stall counts down
  a_r9_idle_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> (!$stable(ins) ||
              ($past(stall_o) == '0 ? stall_o == '0
                                    : stall_o == $past(stall_o) - CNT_W'(1))));
endmodule

bind dep_scoreboard dep_scoreboard_checker #(.AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_valid_i (issue_valid_i),
  .cls_i         (cls_i),
  .dst_i         (dst_i),
  .dst_en_i      (dst_en_i),
  .src0_i        (src0_i),
  .src0_en_i     (src0_en_i),
  .src1_i        (src1_i),
  .src1_en_i     (src1_en_i),
  .guard_i       (guard_i),
  .ready_o       (ready_o),
  .stall_o       (stall_o)
);

// File: tb/dep_scoreboard_test.sv
module dep_scoreboard_test;
  localparam int NR = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          issue_valid_i = 1'b0;
  logic [1:0]    cls_i = '0;
  logic [AW-1:0] dst_i = '0, src0_i = '0, src1_i = '0;
  logic          dst_en_i = 1'b0, src0_en_i = 1'b0, src1_en_i = 1'b0;
  logic [1:0]    guard_i = '0;
  logic          ready_o;
  logic [3:0]    stall_o;

  int checks = 0;
  int errors = 0;
  int m_age [NR];
  int m_cls [NR];

  always #5 clk = ~clk;

  dep_scoreboard #(.NUM_REGS(NR)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .issue_valid_i(issue_valid_i), .cls_i(cls_i),
    .dst_i(dst_i), .dst_en_i(dst_en_i), .src0_i(src0_i), .src0_en_i(src0_en_i),
    .src1_i(src1_i), .src1_en_i(src1_en_i), .guard_i(guard_i),
    .ready_o(ready_o), .stall_o(stall_o)
  );

  function automatic int dlat(int c);
    case (c)
      0: return 2;
      1: return 4;
      2: return 9;
      default: return 3;
    endcase
  endfunction

  function automatic int true_need(int p, int c, int g);
    if (p == 3) begin
      if (g[0] && (c == 1 || c == 2)) return 2;
      if (g[1] && c == 1) return 3;
      if (c != 3) return 4;
    end
    return dlat(p);
  endfunction

  function automatic int exp_stall(int c, int d, bit de, int s0, bit s0e,
                                   int s1, bit s1e, int g);
    int m = 0, t;
    if (s0e && s0 != 0) begin t = true_need(m_cls[s0], c, g) - m_age[s0]; if (t > m) m = t; end
    if (s1e && s1 != 0) begin t = true_need(m_cls[s1], c, g) - m_age[s1]; if (t > m) m = t; end
    if (de && d != 0) begin
      t = dlat(m_cls[d]) - dlat(c);
      if (t < 0) t = 0;
      t = t - m_age[d];
      if (t > m) m = t;
    end
    return m;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, int c, int d, bit de, int s0, bit s0e, int s1, bit s1e,
                      int g, int exp, string tag);
    int e;
    @(negedge clk);
    issue_valid_i = v; cls_i = 2'(c); dst_i = AW'(d); dst_en_i = de;
    src0_i = AW'(s0); src0_en_i = s0e; src1_i = AW'(s1); src1_en_i = s1e; guard_i = 2'(g);
    #1;
    e = exp_stall(c, d, de, s0, s0e, s1, s1e, g);
    check(tag, int'(stall_o), e, "stall");
    if (exp >= 0) check(tag, int'(stall_o), exp, "stall_directed");
    check("R10", int'(ready_o), int'(e == 0), "ready");
    @(posedge clk);
    for (int r = 0; r < NR; r++) if (m_age[r] < 100) m_age[r]++;
    if (v && e == 0 && de && d != 0) begin
      m_age[d] = 1;
      m_cls[d] = c;
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < NR; r++) begin m_age[r] = 100; m_cls[r] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset state
    step(0, 0, 7, 1, 3, 1, 5, 1, 0, 0, "R1");
    // R2 divide latency, R9 rejection
    step(1, 2, 1, 1, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 1, 1, 0, 0, 0, 8, "R2");
    step(0, 0, 0, 0, 1, 1, 0, 0, 0, 7, "R9");
    step(1, 0, 2, 1, 1, 1, 0, 0, 0, 6, "R9");
    step(0, 0, 0, 0, 2, 1, 0, 0, 0, 0, "R9");
    // R2 multiply and simple
    step(1, 1, 3, 1, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 3, 1, 0, 3, "R2");
    step(1, 0, 4, 1, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 2, 0, 0, 4, 1, 0, 0, 0, 1, "R2");
    // R5 float to float
    step(1, 3, 5, 1, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 3, 0, 0, 5, 1, 0, 0, 0, 2, "R5");
    // R3 float to simple
    step(1, 3, 6, 1, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 6, 1, 0, 0, 0, 3, "R3");
    // R4 guard priority
    step(1, 3, 7, 1, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 1, 0, 0, 7, 1, 0, 0, 3, 1, "R4");
    step(1, 3, 8, 1, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 1, 0, 0, 8, 1, 0, 0, 2, 2, "R4");
    step(1, 3, 9, 1, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 1, 0, 0, 9, 1, 0, 0, 0, 3, "R4");
    step(1, 3, 10, 1, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 10, 1, 0, 0, 3, 3, "R4");
    step(1, 3, 11, 1, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 2, 0, 0, 11, 1, 0, 0, 2, 3, "R4");
    // R6 output dependences
    step(1, 2, 12, 1, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 12, 1, 0, 0, 0, 0, 0, 6, "R6");
    step(1, 0, 13, 1, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 2, 13, 1, 0, 0, 0, 0, 0, 0, "R6");
    step(1, 1, 14, 1, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 14, 1, 0, 0, 0, 0, 0, 1, "R6");
    // R7 anti dependence
    repeat (10) idle();
    step(1, 0, 0, 0, 15, 1, 0, 0, 0, 0, "R7");
    step(1, 2, 15, 1, 0, 0, 0, 0, 0, 0, "R7");
    // R8 register 0 and disabled destination
    step(1, 2, 0, 1, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R8");
    step(1, 2, 2, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 2, 1, 0, 0, 0, 0, "R8");
    // R10 maximum over operands
    repeat (10) idle();
    step(1, 2, 1, 1, 0, 0, 0, 0, 0, 0, "R10");
    step(1, 1, 3, 1, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 3, 1, 1, 1, 0, 7, "R10");

    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 4) != 0, $urandom % 4, $urandom % 8, $urandom % 2,
           $urandom % 8, $urandom % 2, $urandom % 8, $urandom % 2,
           $urandom % 4, -1, "R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule